// File: doc/BRIEF.md
# Core memory read-restore sequencer

This block runs one coincident-current core stack of 2^13 locations. Each location holds a 13-bit data syllable and one parity bit, so the stack has 14 bit planes. A requester presents one request: an address, a read/write flag and write data. The block then times the whole access itself and needs no further handshake. The 13-bit address splits into a 7-bit X line index (upper bits) and a 6-bit Y line index (lower bits).

Reading a core is destructive. A read pulse forces every selected core to 0, and a plane reports a 1 only if its core flipped. So every access starts with a clearing read, then samples the 14 sense outputs, then drives a write pulse that sets every selected core to 1. During the write pulse, any plane whose inhibit line is active keeps its core at 0, so zeros are written through the inhibit lines. A read request restores the sensed word and returns the data, with a parity error flag if the sensed word has an even number of ones. A write request ignores what it sensed and stores the new data with an odd-parity bit.

The controller has five states:
- `ST_IDLE` moves to `ST_READ_DRIVE` when a request arrives.
- `ST_READ_DRIVE` lasts `RD_CYCLES` cycles and then moves to `ST_SENSE_STROBE`.
- `ST_SENSE_STROBE` lasts one cycle and then moves to `ST_WRITE_DRIVE`.
- `ST_WRITE_DRIVE` lasts `WR_CYCLES` cycles and then moves to `ST_DONE`.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `core_rr_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `busy`, `done`, `drive_read`, `sense_strobe`, `drive_write` and `par_err` are 0, and `inhibit` is all zero.
- R2: For the whole time `busy` is high, `x_idx` equals the upper `X_BITS` bits and `y_idx` equals the lower `Y_BITS` bits of the address that was accepted.
- R3: After a request is accepted, `drive_read` is high for exactly `RD_CYCLES` cycles, then `sense_strobe` for exactly one cycle, then `drive_write` for exactly `WR_CYCLES` cycles. `done` is high for one cycle, `RD_CYCLES+WR_CYCLES+2` clock edges after the accepting edge. `drive_read` and `drive_write` are never high together.
- R4: For a read, `rd_data` in the `done` cycle equals bits 12..0 of the word sensed in the strobe cycle.
- R5: For a read, during `drive_write` the `inhibit` lines equal the bitwise inverse of the sensed 14-bit word, so the location holds its original contents afterwards.
- R6: For a write, the stored word is the data in bits 12..0 and, in bit 13, an odd-parity bit chosen so the 14 bits hold an odd number of ones. `inhibit` equals the inverse of that word during `drive_write` and is all zero in every other cycle.
- R7: For a write, the sensed value is discarded: `rd_data` is 0 and `par_err` is 0 in the `done` cycle.
- R8: For a read, `par_err` is 1 in the `done` cycle exactly when the sensed 14-bit word holds an even number of ones, and `par_err` is 0 whenever `done` is 0.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle and low after it. A request presented while `busy` is high is ignored: the running access keeps its address and timing, and the location the ignored request named is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; sampled only in idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | X_BITS+Y_BITS | Location address |
| req_wdata | input | DATA_W | Data for a write access |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read data, valid with `done` |
| par_err | output | 1 | Parity mismatch, only with `done` |
| x_idx | output | X_BITS | Selected X line |
| y_idx | output | Y_BITS | Selected Y line |
| drive_read | output | 1 | Clearing read pulse to the stack |
| sense_strobe | output | 1 | Sense sampling window |
| drive_write | output | 1 | Write pulse to the stack |
| inhibit | output | DATA_W+1 | Per-plane inhibit, 1 keeps the core at 0 |
| sense_in | input | DATA_W+1 | Per-plane sense outputs from the stack |

## Verification
The requester is accepted on the first edge where the block is idle and `req_valid` is high. The bench counts clock edges from that edge and samples on falling edges. It expects `drive_read` on samples 1 to RD_CYCLES, the strobe on the next sample, and `drive_write` on the WR_CYCLES samples after that. It expects `done`, `rd_data` and `par_err` on sample RD_CYCLES+WR_CYCLES+2, and `busy` low on the sample after. The phase counts and the `done` position are compared with those numbers. The restored or written contents are read from the bench's destructive-read stack model only after `done`. An ignored request is injected on the second and third samples of a running access, and the location it named is checked afterwards.

// File: rtl/core_rr_pkg.sv
package core_rr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DRIVE,
        ST_SENSE_STROBE,
        ST_WRITE_DRIVE,
        ST_DONE
    } phase_t;

endpackage

// File: rtl/core_rr_parity.sv
// Odd-parity generator: odd_bit makes data plus odd_bit hold an odd count of ones.
module core_rr_parity #(
    parameter int W = 13
) (
    input  logic [W-1:0] data,
    output logic         odd_bit
);

    logic [W:0] chain;

    assign chain[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ data[i];
    end

    assign odd_bit = chain[W];

endmodule

// File: rtl/core_rr_timer.sv
// Down-counter that times one drive phase.
module core_rr_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/core_rr_datapath.sv
// Holds the accepted request, captures the sense word and forms the inhibit pattern.
module core_rr_datapath #(
    parameter int X_BITS = 7,
    parameter int Y_BITS = 6,
    parameter int DATA_W = 13,
    localparam int ADDR_W = X_BITS + Y_BITS,
    localparam int PLANES = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic              write_phase,
    input  logic [PLANES-1:0] sense_in,
    output logic [X_BITS-1:0] x_idx,
    output logic [Y_BITS-1:0] y_idx,
    output logic [PLANES-1:0] inhibit,
    output logic [DATA_W-1:0] rd_data,
    output logic              parity_bad,
    output logic              op_write
);

    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [PLANES-1:0] wword_q;
    logic [PLANES-1:0] sensed_q;
    logic [PLANES-1:0] store_word;
    logic              gen_bit;
    logic              even_count;

    core_rr_parity #(.W(DATA_W)) i_gen (
        .data    (req_wdata),
        .odd_bit (gen_bit)
    );

    // A correctly stored word has an odd count of ones, so this output is 1 on error.
    core_rr_parity #(.W(PLANES)) i_chk (
        .data    (sensed_q),
        .odd_bit (even_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wr_q     <= 1'b0;
            wword_q  <= '0;
            sensed_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wr_q    <= req_write;
                wword_q <= {gen_bit, req_wdata};
            end
            if (capture) begin
                sensed_q <= sense_in;
            end
        end
    end

    always_comb begin
        store_word = wr_q ? wword_q : sensed_q;
        inhibit    = write_phase ? ~store_word : '0;
        rd_data    = wr_q ? '0 : sensed_q[DATA_W-1:0];
        parity_bad = !wr_q && even_count;
    end

    assign x_idx    = addr_q[ADDR_W-1:Y_BITS];
    assign y_idx    = addr_q[Y_BITS-1:0];
    assign op_write = wr_q;

    // R6: the inhibit pattern does not change during one write drive
    a_r6_inhibit_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (write_phase && $past(write_phase)) |-> $stable(inhibit));

endmodule

// File: rtl/core_rr_seq.sv
// Read-restore sequencer for one coincident-current core stack.
module core_rr_seq
    import core_rr_pkg::*;
#(
    parameter int X_BITS    = 7,
    parameter int Y_BITS    = 6,
    parameter int DATA_W    = 13,
    parameter int RD_CYCLES = 4,
    parameter int WR_CYCLES = 4,
    localparam int ADDR_W = X_BITS + Y_BITS,
    localparam int PLANES = DATA_W + 1,
    localparam int MAX_CYC = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES,
    localparam int CNT_W  = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              par_err,
    output logic [X_BITS-1:0] x_idx,
    output logic [Y_BITS-1:0] y_idx,
    output logic              drive_read,
    output logic              sense_strobe,
    output logic              drive_write,
    output logic [PLANES-1:0] inhibit,
    input  logic [PLANES-1:0] sense_in
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYCLES - 1);

    phase_t           state_q, state_d;
    logic             accept;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_expired;
    logic             parity_bad;
    logic             op_write;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign t_load = accept || (state_q == ST_SENSE_STROBE);
    assign t_val  = accept ? RD_LOAD : WR_LOAD;

    core_rr_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    core_rr_datapath #(
        .X_BITS (X_BITS),
        .Y_BITS (Y_BITS),
        .DATA_W (DATA_W)
    ) i_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .capture     (sense_strobe),
        .write_phase (drive_write),
        .sense_in    (sense_in),
        .x_idx       (x_idx),
        .y_idx       (y_idx),
        .inhibit     (inhibit),
        .rd_data     (rd_data),
        .parity_bad  (parity_bad),
        .op_write    (op_write)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (req_valid) state_d = ST_READ_DRIVE;
            ST_READ_DRIVE:   if (t_expired) state_d = ST_SENSE_STROBE;
            ST_SENSE_STROBE: state_d = ST_WRITE_DRIVE;
            ST_WRITE_DRIVE:  if (t_expired) state_d = ST_DONE;
            ST_DONE:         state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy         = 1'b0;
        done         = 1'b0;
        drive_read   = 1'b0;
        sense_strobe = 1'b0;
        drive_write  = 1'b0;
        par_err      = 1'b0;
        unique case (state_q)
            ST_IDLE:         ;
            ST_READ_DRIVE:   begin busy = 1'b1; drive_read   = 1'b1; end
            ST_SENSE_STROBE: begin busy = 1'b1; sense_strobe = 1'b1; end
            ST_WRITE_DRIVE:  begin busy = 1'b1; drive_write  = 1'b1; end
            ST_DONE:         begin busy = 1'b1; done = 1'b1; par_err = parity_bad; end
            default:         ;
        endcase
    end

    // R3: the read pulse and the write pulse never overlap
    a_r3_drive_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_read && drive_write));

    // R3: the sense strobe is always followed by the write drive
    a_r3_strobe_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        sense_strobe |=> drive_write);

    // R3: done lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done is reported inside the busy window
    a_r9_busy_covers_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2: the selected lines hold still during an access
    a_r2_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({x_idx, y_idx}));

    // R8: the parity flag appears only with done
    a_r8_perr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> done);

    // R7: a write access returns no read data and no parity flag
    a_r7_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_write) |-> (rd_data == '0 && !par_err));

endmodule

// File: tb/test_core_rr_seq.sv
`timescale 1ns/1ps
module test_core_rr_seq;

    localparam int XB = 3;
    localparam int YB = 2;
    localparam int DW = 13;
    localparam int RDC = 3;
    localparam int WRC = 2;
    localparam int AW = XB + YB;
    localparam int NW = 1 << AW;
    localparam int PL = DW + 1;
    localparam int LAT = RDC + WRC + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done, par_err, drive_read, sense_strobe, drive_write;
    logic [DW-1:0] rd_data;
    logic [XB-1:0] x_idx;
    logic [YB-1:0] y_idx;
    logic [PL-1:0] inhibit;
    logic [PL-1:0] sense_in;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    core_rr_seq #(
        .X_BITS(XB), .Y_BITS(YB), .DATA_W(DW), .RD_CYCLES(RDC), .WR_CYCLES(WRC)
    ) i_core_rr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .par_err(par_err), .x_idx(x_idx), .y_idx(y_idx),
        .drive_read(drive_read), .sense_strobe(sense_strobe), .drive_write(drive_write),
        .inhibit(inhibit), .sense_in(sense_in)
    );

    // Behavioural core stack: read clears the word and ORs flipped cores into sense,
    // write sets every core whose inhibit line is low.
    logic [PL-1:0] mem [NW];
    logic [PL-1:0] sense_q = '0;
    assign sense_in = sense_q;

    always @(posedge clk) begin
        if (drive_read) begin
            sense_q <= sense_q | mem[{x_idx, y_idx}];
            mem[{x_idx, y_idx}] <= '0;
        end else if (drive_write) begin
            mem[{x_idx, y_idx}] <= ~inhibit;
            sense_q <= '0;
        end
    end

    function automatic logic [PL-1:0] with_par(input logic [DW-1:0] d);
        return {~(^d), d};
    endfunction

    function automatic logic [DW-1:0] rpat(input int a);
        if (a == 1) return '0;
        if (a == 2) return '1;
        return DW'(a * 757 + 163);
    endfunction

    function automatic logic [DW-1:0] wpat(input int a);
        if (a == 3) return '0;
        if (a == 4) return '1;
        return DW'((a * 935) ^ 341);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input int a, input logic [DW-1:0] wd,
                          input bit inject, input int inj_a);
        logic [PL-1:0] exp_word;
        int lat, rc, sc, wc;
        bit bad_inh, bad_xy, bad_busy;
        exp_word = wr ? with_par(wd) : mem[a];
        lat = 0; rc = 0; sc = 0; wc = 0;
        bad_inh = 0; bad_xy = 0; bad_busy = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
        @(posedge clk);
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 1) req_valid = 1'b0;
            if (inject && lat == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(inj_a); req_wdata = '0;
            end
            if (inject && lat == 3) req_valid = 1'b0;
            if (!busy) bad_busy = 1;
            if (drive_read) rc++;
            if (sense_strobe) sc++;
            if (drive_write) begin
                wc++;
                if (inhibit !== ~exp_word) bad_inh = 1;
            end else if (inhibit !== '0) bad_inh = 1;
            if (x_idx !== XB'(a >> YB) || y_idx !== YB'(a)) bad_xy = 1;
            if (done || lat > 64) break;
        end
        check(lat == LAT, "R3", "done position", lat, LAT);
        check(rc == RDC && sc == 1 && wc == WRC, "R3", "phase lengths",
              rc * 100 + sc * 10 + wc, RDC * 100 + 10 + WRC);
        check(!bad_xy, "R2", "line indices", bad_xy, 0);
        check(!bad_busy, "R9", "busy window", bad_busy, 0);
        if (wr) begin
            check(!bad_inh, "R6", "write inhibit", bad_inh, 0);
            check(rd_data === '0 && par_err === 1'b0, "R7", "write discards sense",
                  {par_err, rd_data}, 0);
        end else begin
            check(!bad_inh, "R5", "restore inhibit", bad_inh, 0);
            check(rd_data === exp_word[DW-1:0], "R4", "read data", rd_data, exp_word[DW-1:0]);
            check(par_err === ~(^exp_word), "R8", "parity flag", par_err, ~(^exp_word));
        end
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && par_err === 1'b0, "R9", "idle after done",
              {busy, done, par_err}, 0);
        check(mem[a] === exp_word, wr ? "R6" : "R5", "stored word", mem[a], exp_word);
    endtask

    initial begin
        for (int a = 0; a < NW; a++) begin
            mem[a] = with_par(rpat(a));
            if (a % 5 == 0) mem[a][DW] = ~mem[a][DW];
        end
        repeat (3) @(negedge clk);
        check(busy === 0 && done === 0 && drive_read === 0 && sense_strobe === 0 &&
              drive_write === 0 && par_err === 0 && inhibit === '0, "R1", "in reset",
              {busy, done, drive_read, sense_strobe, drive_write, par_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 0 && done === 0 && drive_read === 0 && drive_write === 0 &&
              inhibit === '0, "R1", "after reset", {busy, done, drive_read, drive_write}, 0);

        // R4 R5 R8: read every location, including bad-parity ones
        for (int a = 0; a < NW; a++) run_op(1'b0, a, '0, 1'b0, 0);
        // R6 R7: write every location
        for (int a = 0; a < NW; a++) run_op(1'b1, a, wpat(a), 1'b0, 0);
        // R4 R8: read back the written words (all good parity)
        for (int a = 0; a < NW; a++) run_op(1'b0, a, '0, 1'b0, 0);

        // R9: a write request during a running read is ignored
        run_op(1'b0, 6, '0, 1'b1, 9);
        check(mem[9] === with_par(wpat(9)), "R9", "ignored request target",
              mem[9], with_par(wpat(9)));
        run_op(1'b0, 9, '0, 1'b0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule